// File: doc/BRIEF.md
# Dual-Thread Functional Unit Scheduler

This block shares one row of eight functional units between two hardware threads, called A and B. Each thread keeps its own program counter and registers and offers one wide operation word per cycle. The word has one slot for each unit class. An empty slot is a no-operation and claims no unit. Each cycle the scheduler decides which threads may issue. It packs the accepted operations into one combined issue word, and every slot of that word is tagged with the thread it came from.

Both integer slots feed a pool of two identical integer units. An integer operation from A and one from B can therefore start together. For the other six unit classes a thread needs that exact unit. A thread issues its whole word or nothing. When the two words cannot both fit, one thread wins through a round-robin priority and the other sees its accept signal low. The losing thread holds its word and tries again. Accept is decided in the same cycle as the request. The combined word is registered and reaches the units on the next clock edge.

Top module: `dual_thread_fu_sched`

## Requirements
- R1: While reset is asserted and after it is released, all issue slots are invalid. The first conflict after reset is won by thread A.
- R2: When the two words need no unit in common and hold at most two integer operations together, both accept signals are high.
- R3: An integer operation from A and one from B issue together. A's operation goes to integer unit 0 and B's to integer unit 1.
- R4: Slot order is 0 Int, 1 Int, 2 Logic, 3 Shift, 4 FP, 5 Mem1, 6 Mem2, 7 Cond. Slot s uses valid bit s and opcode bits s*6+5..s*6. Operations from different threads in different non-integer slots issue in the same cycle, each in its own slot.
- R5: A slot whose valid bit is 0 claims no unit, whatever its opcode bits hold. An issue slot that no thread uses shows valid 0, tag 0 and opcode 0.
- R6: If both threads hold a valid operation in the same non-integer slot, exactly one thread is accepted. None of the losing thread's operations appear in the issue word.
- R7: If the two words together hold more than two valid integer operations, this counts as a conflict and only one thread is accepted.
- R8: The priority passes to the other thread after every conflict cycle. It stays unchanged in cycles without a conflict.
- R9: The issue word captured at a clock edge holds the accepted operations of the cycle before that edge. Each issue slot carries a valid bit, a tag (0 = thread A, 1 = thread B) and the opcode.
- R10: A word with no valid slot is always accepted and takes no unit.
- R11: Integer operations fill unit 0 before unit 1. Thread A's operations come first, in slot order, and thread B's follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ta_slot_vld | input | 8 | Thread A slot valid bits |
| ta_slot_opc | input | 48 | Thread A opcodes, 6 bits per slot |
| tb_slot_vld | input | 8 | Thread B slot valid bits |
| tb_slot_opc | input | 48 | Thread B opcodes, 6 bits per slot |
| ta_accept | output | 1 | Thread A word issues this cycle |
| tb_accept | output | 1 | Thread B word issues this cycle |
| iss_vld | output | 8 | Registered issue slot valid bits |
| iss_tag | output | 8 | Registered issue slot thread tags |
| iss_opc | output | 48 | Registered issue opcodes, 6 bits per slot |

## Verification
The assertions assume that a thread's valid bits are only known values once reset is released. They also assume that a thread's word is judged as a whole in the cycle it is offered. Nothing in them depends on a stalled thread holding its word, so the bench can change both words freely from one cycle to the next. The bench drives every word on the falling edge, while reset is already low. It reads the accept signals before the next rising edge and the issue word just after that edge. This way each scenario covers exactly one scheduling decision and one change of priority.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int UNITS_DEF = 8;
    localparam int INTS_DEF  = 2;
    localparam int OPC_DEF   = 6;

    typedef enum logic {
        THR_A = 1'b0,
        THR_B = 1'b1
    } thread_e;
endpackage

// File: rtl/fu_conflict_detect.sv
module fu_conflict_detect #(
    parameter int NUM_UNITS = sched_pkg::UNITS_DEF,
    parameter int NUM_INT   = sched_pkg::INTS_DEF
) (
    input  logic [NUM_UNITS-1:0] a_vld,
    input  logic [NUM_UNITS-1:0] b_vld,
    output logic                 conflict
);
    localparam int CNT_W = $clog2(2*NUM_INT + 1) + 1;

    logic [CNT_W-1:0] int_total;
    logic             shared_clash;
    logic             int_over;

    always_comb begin
        int_total = '0;
        for (int k = 0; k < NUM_INT; k++) begin
            int_total = int_total + CNT_W'(a_vld[k]) + CNT_W'(b_vld[k]);
        end
        shared_clash = 1'b0;
        for (int s = NUM_INT; s < NUM_UNITS; s++) begin
            shared_clash = shared_clash | (a_vld[s] & b_vld[s]);
        end
        int_over = (int_total > CNT_W'(NUM_INT));
        conflict = shared_clash | int_over;
    end
endmodule

// File: rtl/rr_thread_arb.sv
module rr_thread_arb (
    input  logic       clk,
    input  logic       rst,
    input  logic       conflict,
    output logic [1:0] accept
);
    import sched_pkg::*;

    typedef struct packed {
        thread_e prio;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (conflict) begin
            st_d.prio = (st_q.prio == THR_A) ? THR_B : THR_A;
            accept    = (st_q.prio == THR_A) ? 2'b01 : 2'b10;
        end else begin
            accept    = 2'b11;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.prio <= THR_A;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    prio_turn_chk: assert property (@(posedge clk) disable iff (rst)
        conflict |=> st_q.prio != $past(st_q.prio));

    // R8
    prio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !conflict |=> $stable(st_q.prio));
endmodule

// File: rtl/issue_merge.sv
module issue_merge #(
    parameter int NUM_UNITS = sched_pkg::UNITS_DEF,
    parameter int NUM_INT   = sched_pkg::INTS_DEF,
    parameter int OPC_W     = sched_pkg::OPC_DEF
) (
    input  logic [1:0]                 accept,
    input  logic [NUM_UNITS-1:0]       a_vld,
    input  logic [NUM_UNITS*OPC_W-1:0] a_opc,
    input  logic [NUM_UNITS-1:0]       b_vld,
    input  logic [NUM_UNITS*OPC_W-1:0] b_opc,
    output logic [NUM_UNITS-1:0]       m_vld,
    output logic [NUM_UNITS-1:0]       m_tag,
    output logic [NUM_UNITS*OPC_W-1:0] m_opc
);
    import sched_pkg::*;

    // integer pool: A's candidates first, then B's, in slot order
    always_comb begin
        int fill;
        m_vld[NUM_INT-1:0]       = '0;
        m_tag[NUM_INT-1:0]       = '0;
        m_opc[NUM_INT*OPC_W-1:0] = '0;
        fill = 0;
        for (int k = 0; k < NUM_INT; k++) begin
            if (accept[0] && a_vld[k] && fill < NUM_INT) begin
                m_vld[fill]               = 1'b1;
                m_tag[fill]               = THR_A;
                m_opc[fill*OPC_W +: OPC_W] = a_opc[k*OPC_W +: OPC_W];
                fill = fill + 1;
            end
        end
        for (int k = 0; k < NUM_INT; k++) begin
            if (accept[1] && b_vld[k] && fill < NUM_INT) begin
                m_vld[fill]               = 1'b1;
                m_tag[fill]               = THR_B;
                m_opc[fill*OPC_W +: OPC_W] = b_opc[k*OPC_W +: OPC_W];
                fill = fill + 1;
            end
        end
    end

    // dedicated units: slot maps straight through
    for (genvar s = NUM_INT; s < NUM_UNITS; s++) begin : g_shared
        always_comb begin
            if (accept[0] && a_vld[s]) begin
                m_vld[s]                = 1'b1;
                m_tag[s]                = THR_A;
                m_opc[s*OPC_W +: OPC_W] = a_opc[s*OPC_W +: OPC_W];
            end else if (accept[1] && b_vld[s]) begin
                m_vld[s]                = 1'b1;
                m_tag[s]                = THR_B;
                m_opc[s*OPC_W +: OPC_W] = b_opc[s*OPC_W +: OPC_W];
            end else begin
                m_vld[s]                = 1'b0;
                m_tag[s]                = 1'b0;
                m_opc[s*OPC_W +: OPC_W] = '0;
            end
        end
    end
endmodule

// File: rtl/dual_thread_fu_sched.sv
module dual_thread_fu_sched #(
    parameter int NUM_UNITS = sched_pkg::UNITS_DEF,
    parameter int NUM_INT   = sched_pkg::INTS_DEF,
    parameter int OPC_W     = sched_pkg::OPC_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_UNITS-1:0]       ta_slot_vld,
    input  logic [NUM_UNITS*OPC_W-1:0] ta_slot_opc,
    input  logic [NUM_UNITS-1:0]       tb_slot_vld,
    input  logic [NUM_UNITS*OPC_W-1:0] tb_slot_opc,
    output logic                       ta_accept,
    output logic                       tb_accept,
    output logic [NUM_UNITS-1:0]       iss_vld,
    output logic [NUM_UNITS-1:0]       iss_tag,
    output logic [NUM_UNITS*OPC_W-1:0] iss_opc
);
    localparam int WORD_W = NUM_UNITS * OPC_W;
    localparam logic [NUM_UNITS-1:0] SHARED_MASK =
        {NUM_UNITS{1'b1}} << NUM_INT;
    localparam logic [NUM_UNITS-1:0] INT_MASK = ~SHARED_MASK;

    typedef struct packed {
        logic [NUM_UNITS-1:0] vld;
        logic [NUM_UNITS-1:0] tag;
        logic [WORD_W-1:0]    opc;
    } iss_st_t;

    iss_st_t st_d, st_q;

    logic                 conflict;
    logic [1:0]           accept;
    logic [NUM_UNITS-1:0] m_vld;
    logic [NUM_UNITS-1:0] m_tag;
    logic [WORD_W-1:0]    m_opc;

    fu_conflict_detect #(
        .NUM_UNITS(NUM_UNITS),
        .NUM_INT  (NUM_INT)
    ) u_detect (
        .a_vld   (ta_slot_vld),
        .b_vld   (tb_slot_vld),
        .conflict(conflict)
    );

    rr_thread_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .conflict(conflict),
        .accept  (accept)
    );

    issue_merge #(
        .NUM_UNITS(NUM_UNITS),
        .NUM_INT  (NUM_INT),
        .OPC_W    (OPC_W)
    ) u_merge (
        .accept(accept),
        .a_vld (ta_slot_vld),
        .a_opc (ta_slot_opc),
        .b_vld (tb_slot_vld),
        .b_opc (tb_slot_opc),
        .m_vld (m_vld),
        .m_tag (m_tag),
        .m_opc (m_opc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = m_vld;
        st_d.tag = m_tag;
        st_d.opc = m_opc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ta_accept = accept[0];
    assign tb_accept = accept[1];
    assign iss_vld   = st_q.vld;
    assign iss_tag   = st_q.tag;
    assign iss_opc   = st_q.opc;

    // R6
    shared_single_win_chk: assert property (@(posedge clk) disable iff (rst)
        (|(ta_slot_vld & tb_slot_vld & SHARED_MASK)) |-> !(ta_accept && tb_accept));

    // R7
    int_pool_limit_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(ta_slot_vld & INT_MASK) + $countones(tb_slot_vld & INT_MASK) > NUM_INT)
        |-> !(ta_accept && tb_accept));

    // R6
    someone_moves_chk: assert property (@(posedge clk) disable iff (rst)
        ta_accept || tb_accept);

    // R11
    int_fill_order_chk: assert property (@(posedge clk) disable iff (rst)
        iss_vld[1] |-> (iss_vld[0] && !(iss_tag[0] && !iss_tag[1])));

    for (genvar s = NUM_INT; s < NUM_UNITS; s++) begin : g_slot_chk
        // R9
        slot_origin_chk: assert property (@(posedge clk) disable iff (rst)
            iss_vld[s] |-> $past((ta_slot_vld[s] && ta_accept) ||
                                 (tb_slot_vld[s] && tb_accept)));
    end
endmodule

// File: tb/dual_thread_fu_sched_bench.sv
module dual_thread_fu_sched_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ta_v = '0, tb_v = '0;
    logic [47:0] ta_o = '0, tb_o = '0;
    logic        ta_acc, tb_acc;
    logic [7:0]  iss_vld, iss_tag;
    logic [47:0] iss_opc;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dual_thread_fu_sched u_dual_thread_fu_sched (
        .clk(clk), .rst(rst),
        .ta_slot_vld(ta_v), .ta_slot_opc(ta_o),
        .tb_slot_vld(tb_v), .tb_slot_opc(tb_o),
        .ta_accept(ta_acc), .tb_accept(tb_acc),
        .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_opc(iss_opc)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {valid, tag, opcode} of one issue slot
    task automatic chk_slot(string req, int s, logic v, logic t, logic [5:0] op);
        chk(req, {55'd0, iss_vld[s], iss_tag[s], iss_opc[s*6 +: 6]}, {55'd0, v, t, op});
    endtask

    function automatic logic [47:0] put(logic [47:0] w, int s, logic [5:0] op);
        logic [47:0] r = w;
        r[s*6 +: 6] = op;
        return r;
    endfunction

    // drive on the falling edge, let accept settle
    task automatic offer(logic [7:0] av, logic [47:0] ao, logic [7:0] bv, logic [47:0] bo);
        @(negedge clk);
        ta_v = av; ta_o = ao; tb_v = bv; tb_o = bo;
        #2;
    endtask

    task automatic capture();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        chk("R1 reset issue valid", {56'd0, iss_vld}, 64'd0);
        chk("R1 reset issue opcodes", {16'd0, iss_opc}, 64'd0);
    endtask

    task automatic t_split_units();
        offer(8'b0000_0100, put('0, 2, 6'h05), 8'b0000_1000, put('0, 3, 6'h09));
        chk("R2 accept both", {62'd0, tb_acc, ta_acc}, 64'd3);
        chk("R9 issue not yet updated", {56'd0, iss_vld}, 64'd0);
        capture();
        chk_slot("R4 logic slot from A", 2, 1'b1, 1'b0, 6'h05);
        chk_slot("R4 shift slot from B", 3, 1'b1, 1'b1, 6'h09);
        chk_slot("R5 unused slot zero", 4, 1'b0, 1'b0, 6'h00);
    endtask

    task automatic t_dual_int();
        offer(8'b01, put('0, 0, 6'h01), 8'b01, put('0, 0, 6'h01));
        chk("R3 both int accepted", {62'd0, tb_acc, ta_acc}, 64'd3);
        capture();
        chk_slot("R3 int unit0 from A", 0, 1'b1, 1'b0, 6'h01);
        chk_slot("R3 int unit1 from B", 1, 1'b1, 1'b1, 6'h01);
        offer(8'b10, put('0, 1, 6'h02), 8'b01, put('0, 0, 6'h03));
        chk("R3 mixed int slots accepted", {62'd0, tb_acc, ta_acc}, 64'd3);
        capture();
        chk_slot("R11 A first in unit0", 0, 1'b1, 1'b0, 6'h02);
        chk_slot("R11 B next in unit1", 1, 1'b1, 1'b1, 6'h03);
    endtask

    task automatic t_nop_slot();
        offer(8'b0000_0000, put(put('0, 4, 6'h3f), 6, 6'h15),
              8'b0001_0000, put('0, 4, 6'h07));
        chk("R5 NOP slot claims nothing", {62'd0, tb_acc, ta_acc}, 64'd3);
        capture();
        chk_slot("R5 FP slot from B", 4, 1'b1, 1'b1, 6'h07);
        chk_slot("R5 NOP opcode hidden", 6, 1'b0, 1'b0, 6'h00);
    endtask

    // A: Logic 0x0C + Mem1 0x0A, B: Mem1 0x0B + Cond 0x0D
    task automatic t_mem_clash(logic a_wins, string tagline);
        logic [47:0] ao = put(put('0, 2, 6'h0c), 5, 6'h0a);
        logic [47:0] bo = put(put('0, 5, 6'h0b), 7, 6'h0d);
        offer(8'b0010_0100, ao, 8'b1010_0000, bo);
        chk({"R6 single winner ", tagline}, {62'd0, tb_acc, ta_acc},
            a_wins ? 64'd1 : 64'd2);
        capture();
        if (a_wins) begin
            chk_slot({"R6 Mem1 from A ", tagline}, 5, 1'b1, 1'b0, 6'h0a);
            chk_slot({"R6 loser Cond absent ", tagline}, 7, 1'b0, 1'b0, 6'h00);
        end else begin
            chk_slot({"R6 Mem1 from B ", tagline}, 5, 1'b1, 1'b1, 6'h0b);
            chk_slot({"R6 loser Logic absent ", tagline}, 2, 1'b0, 1'b0, 6'h00);
        end
    endtask

    task automatic t_quiet();
        offer(8'b0001_0000, put('0, 4, 6'h04), 8'h00, '0);
        chk("R10 empty B accepted", {62'd0, tb_acc, ta_acc}, 64'd3);
        capture();
        chk_slot("R9 FP tagged A", 4, 1'b1, 1'b0, 6'h04);
    endtask

    task automatic t_int_overflow();
        offer(8'b11, put(put('0, 0, 6'h11), 1, 6'h12), 8'b10, put('0, 1, 6'h13));
        chk("R7 int overflow B wins", {62'd0, tb_acc, ta_acc}, 64'd2);
        capture();
        chk_slot("R7 unit0 from B", 0, 1'b1, 1'b1, 6'h13);
        chk_slot("R7 unit1 empty", 1, 1'b0, 1'b0, 6'h00);
    endtask

    task automatic t_a_pair();
        offer(8'b11, put(put('0, 0, 6'h21), 1, 6'h22), 8'h00, '0);
        chk("R10 pair alone accepted", {62'd0, tb_acc, ta_acc}, 64'd3);
        capture();
        chk_slot("R11 slot0 op in unit0", 0, 1'b1, 1'b0, 6'h21);
        chk_slot("R11 slot1 op in unit1", 1, 1'b1, 1'b0, 6'h22);
        chk("R10 nothing else issued", {56'd0, iss_vld}, 64'h03);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        t_reset();
        t_split_units();
        t_dual_int();
        t_nop_slot();
        t_mem_clash(1'b1, "R1 first conflict");
        t_quiet();
        t_mem_clash(1'b0, "R8 turn passed");
        t_mem_clash(1'b1, "R8 turn back");
        t_int_overflow();
        t_a_pair();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule